// File: doc/BRIEF.md
# Cross-Domain Timer Register Write Bridge

This block sits between a host bus on the system clock and five timer registers that are clocked by a separately selected timer clock. The five registers are a counter preset, two compare values and two control words. The timer clock is either the host clock itself or a secondary oscillator. The oscillator comes from a crystal input, or from a direct clock on the oscillator pin when the external-clock option is set. The counting and compare logic that consumes these registers is outside this block.

The host writes a value into a per-register holding copy in the host domain. In synchronous mode the timer copy loads on the next host edge. In asynchronous mode a toggle request crosses a two-flop synchroniser into the timer domain, and the timer copy loads from the holding copy. An acknowledge toggle then crosses back through two flops. A busy flag for each register stays set from the accepted write until that acknowledge arrives.

The host port carries no valid/ready pair and has no back-pressure. Every write is taken in the cycle it is presented. A write that hits a busy register is dropped and reported on an error pulse. Flipping the clock-select bit wipes all five registers on both sides of the boundary.

Top module: `tmr_xdom_bridge`

## Requirements
- R1: After reset, every holding register, every timer-side register, the mode bits and the status word read zero, `xtal_en` is high and `wr_err` is low.
- R2: `tmr_clk` equals `host_clk` while the clock-select bit is 0. While it is 1, `tmr_clk` equals `osc_pin` if the external-clock bit is 1 and `xtal_clk` otherwise. `xtal_en` is the inverse of the external-clock bit.
- R3: With clock-select 0, a write to address 0..4 appears on that register's timer field and pulses its `tmr_load` bit after the next `host_clk` rising edge. All busy bits read 0.
- R4: With clock-select 1, an accepted write to address 0..4 sets that register's busy bit from the next host cycle on.
- R5: In asynchronous mode the timer field keeps its old value until the transfer lands. When busy falls, the timer field equals the holding register.
- R6: A write to a register whose busy bit is set is dropped. The holding value and the transfer in flight are unchanged, and `wr_err` is high for the one host cycle after that write.
- R7: A holding register does not change while its busy bit is set.
- R8: A write to the mode register that changes the clock-select bit clears all five holding and timer registers to zero and clears every busy bit. A mode write that leaves clock-select unchanged clears nothing.
- R9: Address 5 is the mode register, with bit 0 clock-select and bit 1 external-clock. Address 6 is status, a read-only word: bits 4:0 are the busy bits of addresses 0..4, bit 5 is clock-select and bit 6 is external-clock.
- R10: Addresses 0..4 are counter preset, compare A, compare B, control A and control B. A read returns the holding register. Timer register i appears on `tmr_regs[i*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host/system clock |
| host_rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | DW | Combinational read data |
| wr_err | output | 1 | Write-while-busy pulse |
| osc_pin | input | 1 | Direct external clock on the oscillator pin |
| xtal_clk | input | 1 | Crystal oscillator output |
| xtal_en | output | 1 | Crystal oscillator enable |
| tmr_clk | output | 1 | Selected timer clock |
| tmr_regs | output | 5*DW | Timer-side register values, flat |
| tmr_load | output | 5 | Per-register load pulse, timer domain |

## Verification
Some rules are checked by assertions on every host cycle: busy never shows in synchronous mode, busy rises after an accepted asynchronous write, a holding register stays frozen while busy, the timer copy matches the holding copy when busy falls, an overrun raises the error pulse, and a select change zeroes the channels. Other behaviour can only be shown by the bench's scenarios. These are the clock routing under each mode combination, the read-back map and status layout, and the fact that a dropped write never reaches the timer field. They also cover the fact that a mode write without a select change leaves the registers alone.

// File: rtl/tbx_pkg.sv
package tbx_pkg;
  localparam int TBX_NREG = 5;
  localparam int TBX_AW = 3;
  localparam logic [TBX_AW-1:0] TBX_A_MODE = 3'd5;
  localparam logic [TBX_AW-1:0] TBX_A_STAT = 3'd6;
endpackage

// File: rtl/tbx_clk_sel.sv
module tbx_clk_sel (
  input  logic host_clk,
  input  logic osc_pin,
  input  logic xtal_clk,
  input  logic sel_async,
  input  logic ext_clk,
  output logic xtal_en,
  output logic tmr_clk
);
  logic osc_src;
  assign osc_src = ext_clk ? osc_pin : xtal_clk;
  assign tmr_clk = sel_async ? osc_src : host_clk;
  assign xtal_en = ~ext_clk;
endmodule

// File: rtl/tbx_mode.sv
module tbx_mode
  import tbx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          host_clk,
  input  logic          host_rst_n,
  input  logic          wr_en,
  input  logic [TBX_AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          sel_async,
  output logic          ext_clk,
  output logic          clr
);
  logic mode_wr;
  assign mode_wr = wr_en && (wr_addr == TBX_A_MODE);

  always_ff @(posedge host_clk or negedge host_rst_n) begin
    if (!host_rst_n) begin
      sel_async <= 1'b0;
      ext_clk   <= 1'b0;
      clr       <= 1'b0;
    end else begin
      clr <= 1'b0;
      if (mode_wr) begin
        sel_async <= wr_data[0];
        ext_clk   <= wr_data[1];
        clr       <= (wr_data[0] != sel_async);
      end
    end
  end

  // R8: a clear pulse lasts exactly one host cycle
  AST_CLR_SINGLE: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    clr |=> !clr) else $error("clear pulse longer than one cycle"); // R8
endmodule

// File: rtl/tbx_chan.sv
module tbx_chan #(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          host_clk,
  input  logic          host_rst_n,
  input  logic          clr,
  input  logic          async_mode,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          err,
  output logic [DW-1:0] hold,
  input  logic          tmr_clk,
  input  logic          tmr_rst_n,
  output logic [DW-1:0] tmr_q,
  output logic          tmr_load
);
  localparam int LAST = SYNC - 1;

  logic            req_tgl;
  logic [SYNC-1:0] ack_s;
  logic [SYNC-1:0] req_s;
  logic            ack_tgl;
  logic            accept;
  logic            pending;

  assign busy   = req_tgl ^ ack_s[LAST];
  assign err    = wr & busy;
  assign accept = wr & ~busy;

  // host side: holding copy, request toggle, acknowledge synchroniser
  always_ff @(posedge host_clk or negedge host_rst_n) begin
    if (!host_rst_n) begin
      hold    <= '0;
      req_tgl <= 1'b0;
      ack_s   <= '0;
    end else if (clr) begin
      hold    <= '0;
      req_tgl <= 1'b0;
      ack_s   <= '0;
    end else begin
      ack_s <= {ack_s[SYNC-2:0], ack_tgl};
      if (accept) begin
        hold <= wdata;
        if (async_mode) req_tgl <= ~req_tgl;
      end
    end
  end

  // timer side: request synchroniser, load, acknowledge toggle
  assign pending = req_s[LAST] ^ ack_tgl;

  always_ff @(posedge tmr_clk or negedge tmr_rst_n) begin
    if (!tmr_rst_n) begin
      req_s    <= '0;
      ack_tgl  <= 1'b0;
      tmr_q    <= '0;
      tmr_load <= 1'b0;
    end else begin
      req_s    <= {req_s[SYNC-2:0], req_tgl};
      tmr_load <= 1'b0;
      if (pending) begin
        tmr_q    <= hold;
        ack_tgl  <= req_s[LAST];
        tmr_load <= 1'b1;
      end else if (wr && !async_mode) begin
        tmr_q    <= wdata;
        tmr_load <= 1'b1;
      end
    end
  end

  AST_SYNC_IDLE: assert property (@(posedge host_clk) disable iff (!host_rst_n || clr)
    !async_mode |-> !busy) else $error("busy in synchronous mode"); // R3
  AST_BUSY_SET: assert property (@(posedge host_clk) disable iff (!host_rst_n || clr)
    (accept && async_mode) |=> busy) else $error("busy not raised"); // R4
  AST_LAND_MATCH: assert property (@(posedge host_clk) disable iff (!host_rst_n || clr)
    $fell(busy) |-> (tmr_q == hold)) else $error("busy fell before load"); // R5
  AST_HOLD_STABLE: assert property (@(posedge host_clk) disable iff (!host_rst_n || clr)
    busy |=> $stable(hold)) else $error("holding copy moved while busy"); // R7
  AST_CLR_ZERO: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    clr |=> (hold == '0 && !busy)) else $error("clear left state"); // R8
endmodule

// File: rtl/tmr_xdom_bridge.sv
module tmr_xdom_bridge
  import tbx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic                   host_clk,
  input  logic                   host_rst_n,
  input  logic                   wr_en,
  input  logic [TBX_AW-1:0]      wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [TBX_AW-1:0]      rd_addr,
  output logic [DW-1:0]          rd_data,
  output logic                   wr_err,
  input  logic                   osc_pin,
  input  logic                   xtal_clk,
  output logic                   xtal_en,
  output logic                   tmr_clk,
  output logic [TBX_NREG*DW-1:0] tmr_regs,
  output logic [TBX_NREG-1:0]    tmr_load
);
  logic                sel_async;
  logic                ext_clk;
  logic                clr;
  logic                tmr_rst_n;
  logic [TBX_NREG-1:0] wr_hit;
  logic [TBX_NREG-1:0] busy_vec;
  logic [TBX_NREG-1:0] err_vec;
  logic [DW-1:0]       hold_arr [TBX_NREG];

  tbx_mode #(.DW(DW)) u_mode (
    .host_clk  (host_clk),
    .host_rst_n(host_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sel_async (sel_async),
    .ext_clk   (ext_clk),
    .clr       (clr)
  );

  tbx_clk_sel u_clk (
    .host_clk (host_clk),
    .osc_pin  (osc_pin),
    .xtal_clk (xtal_clk),
    .sel_async(sel_async),
    .ext_clk  (ext_clk),
    .xtal_en  (xtal_en),
    .tmr_clk  (tmr_clk)
  );

  // timer side is wiped asynchronously while a select change clears
  assign tmr_rst_n = host_rst_n & ~clr;

  for (genvar i = 0; i < TBX_NREG; i++) begin : g_ch
    assign wr_hit[i] = wr_en && (wr_addr == TBX_AW'(i));
    tbx_chan #(.DW(DW), .SYNC(SYNC)) u_ch (
      .host_clk  (host_clk),
      .host_rst_n(host_rst_n),
      .clr       (clr),
      .async_mode(sel_async),
      .wr        (wr_hit[i]),
      .wdata     (wr_data),
      .busy      (busy_vec[i]),
      .err       (err_vec[i]),
      .hold      (hold_arr[i]),
      .tmr_clk   (tmr_clk),
      .tmr_rst_n (tmr_rst_n),
      .tmr_q     (tmr_regs[i*DW +: DW]),
      .tmr_load  (tmr_load[i])
    );
  end

  always_ff @(posedge host_clk or negedge host_rst_n) begin
    if (!host_rst_n) wr_err <= 1'b0;
    else             wr_err <= |err_vec;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < TBX_NREG; i++) begin
      if (rd_addr == TBX_AW'(i)) rd_data = hold_arr[i];
    end
    if (rd_addr == TBX_A_MODE) rd_data[1:0] = {ext_clk, sel_async};
    if (rd_addr == TBX_A_STAT) begin
      rd_data[TBX_NREG-1:0] = busy_vec;
      rd_data[TBX_NREG]     = sel_async;
      rd_data[TBX_NREG+1]   = ext_clk;
    end
  end

  AST_OVERRUN_FLAG: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    (|(wr_hit & busy_vec)) |=> wr_err) else $error("overrun not flagged"); // R6
  AST_ERR_CAUSE: assert property (@(posedge host_clk) disable iff (!host_rst_n)
    !(|(wr_hit & busy_vec)) |=> !wr_err) else $error("spurious overrun"); // R6
endmodule

// File: tb/sim_tmr_xdom_bridge.sv
module sim_tmr_xdom_bridge;
  localparam int DW = 8;
  localparam int NR = 5;

  logic host_clk = 1'b0;
  logic osc_pin = 1'b0;
  logic xtal_clk = 1'b0;
  logic host_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic wr_err, xtal_en, tmr_clk;
  logic [NR*DW-1:0] tmr_regs;
  logic [NR-1:0] tmr_load;

  int total = 0;
  int bad = 0;

  always #5 host_clk = ~host_clk;
  always #17 osc_pin = ~osc_pin;
  always #23 xtal_clk = ~xtal_clk;

  tmr_xdom_bridge #(.DW(DW), .SYNC(2)) u0 (
    .host_clk(host_clk), .host_rst_n(host_rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wr_err(wr_err),
    .osc_pin(osc_pin), .xtal_clk(xtal_clk), .xtal_en(xtal_en), .tmr_clk(tmr_clk),
    .tmr_regs(tmr_regs), .tmr_load(tmr_load)
  );

  // {address, data} pairs written in synchronous mode
  localparam logic [10:0] VEC [6] = '{
    {3'd0, 8'h3C}, {3'd1, 8'hA5}, {3'd2, 8'h01},
    {3'd3, 8'hFF}, {3'd4, 8'h5A}, {3'd0, 8'hC3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge host_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge host_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  function automatic logic [DW-1:0] fld(input int i);
    return tmr_regs[i*DW +: DW];
  endfunction

  task automatic wait_idle(output bit ok);
    logic [DW-1:0] s;
    ok = 1'b0;
    for (int n = 0; n < 100; n++) begin
      @(negedge host_clk);
      rd(3'd6, s);
      if (s[NR-1:0] == '0) begin ok = 1'b1; break; end
    end
  endtask

  task automatic all_zero(input string tag);
    logic [DW-1:0] d;
    for (int i = 0; i < NR; i++) begin
      rd(3'(i), d);
      chk(d == '0, tag, d, 0);
    end
    chk(tmr_regs == '0, tag, int'(tmr_regs[31:0]), 0);
  endtask

  task automatic clk_match(input int src, input string tag);
    // src: 0 host, 1 osc_pin, 2 xtal
    for (int k = 0; k < 6; k++) begin
      #7;
      case (src)
        0: chk(tmr_clk === host_clk, tag, tmr_clk, host_clk);
        1: chk(tmr_clk === osc_pin, tag, tmr_clk, osc_pin);
        default: chk(tmr_clk === xtal_clk, tag, tmr_clk, xtal_clk);
      endcase
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    bit ok;
    repeat (3) @(negedge host_clk);
    host_rst_n = 1'b1;
    @(negedge host_clk);

    // R1: reset state
    all_zero("R1 regs");
    rd(3'd6, d); chk(d == '0, "R1 status", d, 0);
    rd(3'd5, d); chk(d == '0, "R1 mode", d, 0);
    chk(xtal_en == 1'b1, "R1 xtal_en", xtal_en, 1);
    chk(wr_err == 1'b0, "R1 wr_err", wr_err, 0);

    // R2: host clock routed in synchronous mode
    clk_match(0, "R2 host clock");

    // R3 / R10: table of synchronous writes
    for (int v = 0; v < 6; v++) begin
      wr(VEC[v][10:8], VEC[v][7:0]);
      chk(fld(int'(VEC[v][10:8])) == VEC[v][7:0], "R3 timer field", fld(int'(VEC[v][10:8])), VEC[v][7:0]);
      chk(tmr_load[VEC[v][10:8]] == 1'b1, "R3 load pulse", tmr_load, 1);
      rd(VEC[v][10:8], d);
      chk(d == VEC[v][7:0], "R10 readback", d, VEC[v][7:0]);
      rd(3'd6, d);
      chk(d[NR-1:0] == '0, "R3 busy zero", d, 0);
    end

    // R9 / R2: external clock bit without select change
    wr(3'd5, 8'h02);
    chk(xtal_en == 1'b0, "R2 xtal_en off", xtal_en, 0);
    rd(3'd6, d); chk(d == 8'h40, "R9 status ext", d, 8'h40);
    rd(3'd5, d); chk(d == 8'h02, "R9 mode read", d, 2);
    chk(fld(0) == 8'hC3, "R8 no clear", fld(0), 8'hC3);

    // R8: select change to asynchronous clears everything
    wr(3'd5, 8'h03);
    @(negedge host_clk);
    all_zero("R8 clear to async");
    rd(3'd6, d); chk(d == 8'h60, "R9 status async ext", d, 8'h60);
    clk_match(1, "R2 osc pin clock");

    // R4 / R5: asynchronous transfer
    wr(3'd2, 8'h77);
    rd(3'd6, d); chk(d[2] == 1'b1, "R4 busy set", d, 8'h64);
    chk(fld(2) == 8'h00, "R5 not yet landed", fld(2), 0);
    wait_idle(ok);
    chk(ok, "R5 busy clears", ok, 1);
    chk(fld(2) == 8'h77, "R5 landed", fld(2), 8'h77);

    // R6: write while busy
    wr(3'd1, 8'h11);
    wr(3'd1, 8'h22);
    chk(wr_err == 1'b1, "R6 error pulse", wr_err, 1);
    rd(3'd1, d); chk(d == 8'h11, "R6 hold kept", d, 8'h11);
    @(negedge host_clk);
    chk(wr_err == 1'b0, "R6 pulse one cycle", wr_err, 0);
    wait_idle(ok);
    chk(ok && fld(1) == 8'h11, "R6 first value lands", fld(1), 8'h11);

    // R2 / R8: switch to crystal, select unchanged
    wr(3'd5, 8'h01);
    chk(xtal_en == 1'b1, "R2 xtal_en on", xtal_en, 1);
    chk(fld(1) == 8'h11, "R8 select unchanged keeps regs", fld(1), 8'h11);
    clk_match(2, "R2 crystal clock");
    wr(3'd3, 8'h3E);
    wait_idle(ok);
    chk(ok && fld(3) == 8'h3E, "R5 crystal transfer", fld(3), 8'h3E);

    // R9: status layout with a busy bit pending
    wr(3'd4, 8'h99);
    rd(3'd6, d); chk(d == 8'h30, "R9 status busy4", d, 8'h30);
    wait_idle(ok);

    // R8: back to synchronous clears again
    wr(3'd5, 8'h00);
    @(negedge host_clk);
    all_zero("R8 clear to sync");
    rd(3'd6, d); chk(d == 8'h00, "R8 status cleared", d, 0);
    clk_match(0, "R2 host clock again");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule